// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave for a Clock Generator

This block is the serial control port of a clock generator. A two-wire bus master reaches eight 8-bit control registers through it. Their bits come out as parallel levels: clock-output enables for several groups and one spread-spectrum enable for the CPU PLL. SCL is only an input. SDA is open-drain: the block reads the line on `sda_i`, and it pulls the line low while `sda_oe` is high. Both lines are oversampled on the system clock through a two-flop synchronizer, and the block never stretches the clock.

The command byte selects the access mode. With bit 7 set, one register is addressed directly by bits 6:0. With bit 7 clear, access is sequential and starts at register 0, with a byte-count phase. Bit 7 of register 7 removes that count phase so that plain two-wire masters can use block transfers. A stop, or a start in the middle of a byte, aborts the transfer. An unaddressed block keeps off the bus until the next start or stop.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address 1101001 (write byte D2h, read byte D3h). For any other address it sends no ACK, and writes that follow it change nothing until the next start or stop.
- R2: After reset `src_en`=FFh, `aux_en`=7Fh, `spread_en`=0, `ext_en`=FFh, `sda_oe`=0. Register 1 reads FEh and register 7 reads 00h.
- R3: A command byte with bit 7 set is a byte access to offset bits 6:0. In a byte write the following data byte lands in that register, and every byte of the transfer is ACKed.
- R4: A byte read (address and command, repeated start, D3h) returns the addressed register MSB first. The master's NACK ends the transfer.
- R5: A command byte with bit 7 clear starts a block write. When the count phase is active, one count byte follows the command and its value is ignored. The data bytes then go to registers 0, 1, 2, … in order, and the master may stop after any complete byte.
- R6: A block read sends the count byte 08h first and then registers 0, 1, 2, …. It keeps sending while the master ACKs and stops sending after a NACK.
- R7: When bit 7 of register 7 is 1, block writes and block reads have no count byte: the first data byte belongs to register 0.
- R8: Offsets 8 and above are ACKed on write, and the data is discarded. Reads of these offsets return 00h, in byte and block mode alike.
- R9: Bits 3, 2 and 0 of register 2 are reserved and always hold 1, whatever is written to them.
- R10: A stop or a start that arrives before the eighth bit of a byte is complete aborts the transfer, and the partial byte is not written.
- R11: `src_en` mirrors register 0, `aux_en` mirrors register 1 bits 7:1, `spread_en` mirrors register 1 bit 0 and `ext_en` mirrors register 2. These outputs change only in the cycle after a register write.
- R12: The block starts pulling SDA low only while SCL is low. It drives the ACK in the ninth clock and read data MSB first, and it releases SDA in idle and after a stop or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| src_en | output | 8 | Clock-output enables from register 0 |
| aux_en | output | 7 | Clock-output enables from register 1 bits 7:1 |
| spread_en | output | 1 | CPU PLL spread-spectrum enable, register 1 bit 0 |
| ext_en | output | 8 | Clock-output enables from register 2 |

## Verification
The bench targets the count phase. It toggles the count-skip bit through ordinary writes and checks that the next block read returns register 0, not 08h, as its first byte. A design that ignored the bit would shift every block transfer by one register. It also writes and reads offsets beyond the register file, where a design that wrapped the offset would corrupt a low register or return its value instead of 00h. Mid-byte stops and starts check that a half-received byte never commits, and a foreign address checks that later bytes do not leak into a register.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    FD_ADDR, FD_CMD, FD_CNT, FD_DATA
  } field_t;
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // Bus lines idle high, so both stages reset to ones: no false edge at reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
  parameter int                  N_REGS    = 8,
  parameter int                  OFS_W     = 7,
  parameter logic [N_REGS*8-1:0] RST_IMAGE = '1,
  parameter logic [N_REGS*8-1:0] FORCE_ONE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [OFS_W-1:0]    wr_ofs,
  input  logic [7:0]          wr_data,
  input  logic [OFS_W-1:0]    rd_ofs,
  output logic [7:0]          rd_data,
  output logic [N_REGS*8-1:0] image
);
  localparam int AW = (N_REGS > 1) ? $clog2(N_REGS) : 1;

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [7:0] q;
    logic [7:0] d;
    logic       hit;

    assign hit = wr_en && (wr_ofs == OFS_W'(g));

    // Reserved bits are ORed in, so they keep their value of 1 whatever is written (R9).
    always_comb begin
      d = q;
      if (hit) d = wr_data | FORCE_ONE[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_IMAGE[g*8 +: 8];
      else        q <= d;
    end

    assign image[g*8 +: 8] = q;
  end

  logic in_range;
  assign in_range = (rd_ofs < OFS_W'(N_REGS));
  assign rd_data  = in_range ? image[{rd_ofs[AW-1:0], 3'b000} +: 8] : 8'h00;
endmodule

// File: rtl/clkcfg_bus_fsm.sv
module clkcfg_bus_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR  = 7'h69,
  parameter logic [7:0] BLK_COUNT = 8'd8,
  parameter int         OFS_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             skip_cnt,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [OFS_W-1:0] wr_ofs,
  output logic [7:0]       wr_data,
  output logic [OFS_W-1:0] rd_ofs,
  output logic             bus_idle
);
  localparam logic [OFS_W-1:0] OFS_MAX = '1;

  phase_t           phase_q, phase_d;
  field_t           field_q, field_d;
  logic [3:0]       bitcnt_q, bitcnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [OFS_W-1:0] ptr_q, ptr_d;
  logic             bmode_q, bmode_d;
  logic             rw_q, rw_d;
  logic             mack_q, mack_d;
  logic             cntp_q, cntp_d;
  logic             oe_q, oe_d;
  logic             scl_q, sda_q;

  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic [OFS_W-1:0] ptr_inc;
  logic [7:0]       tx_load;

  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
  assign ptr_inc  = (ptr_q == OFS_MAX) ? ptr_q : ptr_q + 1'b1;
  assign tx_load  = cntp_q ? BLK_COUNT : rd_data;

  always_comb begin
    phase_d  = phase_q;
    field_d  = field_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    bmode_d  = bmode_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    cntp_d   = cntp_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;

    if (start_ev) begin
      phase_d  = PH_RX;
      field_d  = FD_ADDR;
      bitcnt_d = 4'd0;
      oe_d     = 1'b0;
    end else if (stop_ev) begin
      phase_d  = PH_IDLE;
      bitcnt_d = 4'd0;
      oe_d     = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            phase_d = PH_ACK;
            oe_d    = 1'b1;
            unique case (field_q)
              FD_ADDR: begin
                if (shreg_q[7:1] != SLV_ADDR) begin
                  phase_d = PH_WAIT;
                  oe_d    = 1'b0;
                end else begin
                  rw_d    = shreg_q[0];
                  field_d = FD_CMD;
                  cntp_d  = !bmode_q && !skip_cnt;
                end
              end
              FD_CMD: begin
                bmode_d = shreg_q[7];
                ptr_d   = shreg_q[7] ? shreg_q[OFS_W-1:0] : '0;
                field_d = (shreg_q[7] || skip_cnt) ? FD_DATA : FD_CNT;
              end
              FD_CNT:  field_d = FD_DATA;
              FD_DATA: begin
                wr_en = 1'b1;
                ptr_d = ptr_inc;
              end
              default: ;
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt_d = 4'd0;
            if (rw_q) begin
              phase_d = PH_TX;
              shreg_d = tx_load;
              oe_d    = !tx_load[7];
              if (cntp_q) cntp_d = 1'b0;
              else        ptr_d  = ptr_inc;
            end else begin
              phase_d = PH_RX;
              oe_d    = 1'b0;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              phase_d = PH_MACK;
              oe_d    = 1'b0;
            end else begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              bitcnt_d = bitcnt_q + 4'd1;
              oe_d     = !shreg_q[6];
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mack_d = sda_s;
          end else if (scl_fall) begin
            bitcnt_d = 4'd0;
            if (!mack_q) begin
              phase_d = PH_TX;
              shreg_d = tx_load;
              oe_d    = !tx_load[7];
              if (cntp_q) cntp_d = 1'b0;
              else        ptr_d  = ptr_inc;
            end else begin
              phase_d = PH_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      field_q  <= FD_ADDR;
      bitcnt_q <= 4'd0;
      shreg_q  <= 8'h00;
      ptr_q    <= '0;
      bmode_q  <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b1;
      cntp_q   <= 1'b0;
      oe_q     <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      field_q  <= field_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      bmode_q  <= bmode_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      cntp_q   <= cntp_d;
      oe_q     <= oe_d;
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign sda_oe   = oe_q;
  assign wr_ofs   = ptr_q;
  assign wr_data  = shreg_q;
  assign rd_ofs   = ptr_q;
  assign bus_idle = (phase_q == PH_IDLE) || (phase_q == PH_WAIT);
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave #(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         N_REGS   = 8,
  parameter int         SKIP_REG = 7,
  parameter int         SKIP_BIT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] src_en,
  output logic [6:0] aux_en,
  output logic       spread_en,
  output logic [7:0] ext_en
);
  localparam int                  OFS_W     = 7;
  localparam int                  IMG_W     = N_REGS * 8;
  localparam logic [IMG_W-1:0]    RST_IMAGE = IMG_W'(64'h0000_0000_00FF_FEFF);
  localparam logic [IMG_W-1:0]    FORCE_ONE = IMG_W'(64'h0000_0000_000D_0000);
  localparam logic [7:0]          BLK_COUNT = 8'(N_REGS);

  logic [1:0] rst_pipe;
  logic       rst_n_i;

  // Asynchronous assertion, release synchronized to clk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic [1:0]       lines_s;
  logic             scl_s, sda_s;
  logic             wr_en, bus_idle;
  logic [OFS_W-1:0] wr_ofs, rd_ofs;
  logic [7:0]       wr_data, rd_data;
  logic [IMG_W-1:0] cfg_image;

  clkcfg_line_sync #(.W(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .raw_i  ({scl_i, sda_i}),
    .sync_o (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  clkcfg_bus_fsm #(
    .SLV_ADDR  (SLV_ADDR),
    .BLK_COUNT (BLK_COUNT),
    .OFS_W     (OFS_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .skip_cnt (cfg_image[SKIP_REG*8 + SKIP_BIT]),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_ofs   (wr_ofs),
    .wr_data  (wr_data),
    .rd_ofs   (rd_ofs),
    .bus_idle (bus_idle)
  );

  clkcfg_regfile #(
    .N_REGS    (N_REGS),
    .OFS_W     (OFS_W),
    .RST_IMAGE (RST_IMAGE),
    .FORCE_ONE (FORCE_ONE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_ofs  (wr_ofs),
    .wr_data (wr_data),
    .rd_ofs  (rd_ofs),
    .rd_data (rd_data),
    .image   (cfg_image)
  );

  assign src_en    = cfg_image[7:0];
  assign aux_en    = cfg_image[15:9];
  assign spread_en = cfg_image[8];
  assign ext_en    = cfg_image[23:16];
endmodule

// File: rtl/clkcfg_smbus_chk.sv
module clkcfg_smbus_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_s,
  input logic       sda_oe,
  input logic       wr_en,
  input logic       bus_idle,
  input logic [7:0] src_en,
  input logic [6:0] aux_en,
  input logic       spread_en,
  input logic [7:0] ext_en
);
  // R12: a new pull-down begins only after SCL was seen low.
  a_r12_pull_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R1: no drive while idle or while another slave is addressed.
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  // R10: a stop condition releases the line.
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> !sda_oe);

  // R10: a start condition releases the line.
  a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !sda_s && $past(sda_s)) |=> !sda_oe);

  // R11: enables move only after a register write strobe.
  a_r11_enables_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(src_en) && $stable(aux_en) && $stable(spread_en) && $stable(ext_en)));
endmodule

bind clkcfg_smbus_slave clkcfg_smbus_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_s     (sda_s),
  .sda_oe    (sda_oe),
  .wr_en     (wr_en),
  .bus_idle  (bus_idle),
  .src_en    (src_en),
  .aux_en    (aux_en),
  .spread_en (spread_en),
  .ext_en    (ext_en)
);

// File: tb/clkcfg_smbus_slave_bench.sv
module clkcfg_smbus_slave_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [7:0] src_en, ext_en;
  logic [6:0] aux_en;
  logic       spread_en;

  int chk = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] m [8];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clkcfg_smbus_slave u_clkcfg_smbus_slave (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
    .sda_oe (sda_oe), .src_en (src_en), .aux_en (aux_en),
    .spread_en (spread_en), .ext_en (ext_en)
  );

  function automatic logic [7:0] exp_rd(input int off);
    return (off < 8) ? m[off] : 8'h00;
  endfunction

  function automatic bit skip_on();
    return m[7][7];
  endfunction

  task automatic model_wr(input int off, input logic [7:0] d);
    if (off < 8) m[off] = (off == 2) ? (d | 8'h0D) : d;
  endtask

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] expv);
    chk++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic m_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
    end
    hold();
  endtask

  task automatic m_wr(input logic [7:0] b, output bit ack);
    m_bits(b, 8);
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
    ack = !sda_line;
    scl_m = 1'b0; hold();
  endtask

  task automatic m_rd(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); scl_m = 1'b1; hold(); b[i] = sda_line; scl_m = 1'b0;
    end
    hold(); sda_m = nack; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold(); sda_m = 1'b1;
  endtask

  task automatic chk_outputs(input string req);
    @(negedge clk);
    cmp(req, {24'h0, src_en}, {24'h0, m[0]});
    cmp(req, {25'h0, aux_en}, {25'h0, m[1][7:1]});
    cmp(req, {31'h0, spread_en}, {31'h0, m[1][0]});
    cmp(req, {24'h0, ext_en}, {24'h0, m[2]});
  endtask

  task automatic t_byte_wr(input int off, input logic [7:0] d);
    bit a0, a1, a2;
    m_start(); m_wr(8'hD2, a0); m_wr({1'b1, 7'(off)}, a1); m_wr(d, a2); m_stop();
    cmp("R3 ack", {29'h0, a0, a1, a2}, 32'h7);
    model_wr(off, d);
  endtask

  task automatic t_byte_rd(input int off);
    bit a0, a1, a2;
    logic [7:0] b;
    m_start(); m_wr(8'hD2, a0); m_wr({1'b1, 7'(off)}, a1);
    m_start(); m_wr(8'hD3, a2); m_rd(1'b1, b); m_stop();
    cmp("R4 ack", {29'h0, a0, a1, a2}, 32'h7);
    cmp((off < 8) ? "R4 data" : "R8 beyond data", {24'h0, b}, {24'h0, exp_rd(off)});
  endtask

  task automatic t_blk_wr(input int n);
    bit a, sk;
    int acks;
    logic [7:0] d;
    acks = 0;
    sk = skip_on();
    m_start(); m_wr(8'hD2, a); acks += a; m_wr(8'h00, a); acks += a;
    if (!sk) begin m_wr(8'(n), a); acks += a; end
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      m_wr(d, a); acks += a;
      model_wr(k, d);
    end
    m_stop();
    cmp(sk ? "R7 R12 ack count" : "R5 R12 ack count", acks, 2 + n + (sk ? 0 : 1));
  endtask

  task automatic t_blk_rd(input int n);
    bit a0, a1, a2, sk;
    logic [7:0] b;
    sk = skip_on();
    m_start(); m_wr(8'hD2, a0); m_wr(8'h00, a1);
    m_start(); m_wr(8'hD3, a2);
    cmp("R6 ack", {29'h0, a0, a1, a2}, 32'h7);
    if (!sk) begin
      m_rd(1'b0, b);
      cmp("R6 count byte", {24'h0, b}, 32'h08);
    end
    for (int k = 0; k < n; k++) begin
      m_rd(k == n - 1, b);
      cmp(sk ? "R7 data order" : "R6 data order", {24'h0, b}, {24'h0, exp_rd(k)});
    end
    m_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    void'($urandom(32'd2024));
    m[0] = 8'hFF; m[1] = 8'hFE; m[2] = 8'hFF;
    for (int i = 3; i < 8; i++) m[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2 reset state
    cmp("R2 sda_oe", {31'h0, sda_oe}, 32'h0);
    chk_outputs("R2 reset outputs");
    t_byte_rd(1);
    t_byte_rd(7);

    // R3 R11 byte write lands and drives outputs
    t_byte_wr(1, 8'h35);
    chk_outputs("R11 mapping after byte write");
    t_byte_rd(1);

    // R9 reserved bits stay 1
    t_byte_wr(2, 8'h00);
    cmp("R9 ext_en", {24'h0, ext_en}, 32'h0D);
    t_byte_rd(2);

    // R8 beyond range: acked, discarded, reads 0
    t_byte_wr(9, 8'hA5);
    t_byte_rd(9);
    chk_outputs("R8 no side effect");
    t_byte_rd(1);

    // R1 foreign address: no ACK, write ignored
    m_start(); m_wr(8'h52, a);
    cmp("R1 foreign nack", {31'h0, a}, 32'h0);
    m_wr(8'h81, a); m_wr(8'h00, a); m_stop();
    chk_outputs("R1 foreign write ignored");

    // R10 stop mid-byte
    m_start(); m_wr(8'hD2, a); m_wr(8'h81, a); m_bits(8'h00, 4); m_stop();
    chk_outputs("R10 stop abort");
    // R10 start mid-byte, then a normal byte read of the same register
    m_start(); m_wr(8'hD2, a); m_wr(8'h80, a); m_bits(8'h0F, 5);
    m_start(); m_wr(8'hD2, a); m_wr(8'h80, a);
    m_start(); m_wr(8'hD3, a); m_rd(1'b1, b); m_stop();
    cmp("R10 start abort", {24'h0, b}, {24'h0, m[0]});

    // R5 R6 block transfers with count phase
    t_blk_wr(3);
    chk_outputs("R5 block write");
    t_blk_rd(8);
    t_blk_rd(10);

    // R7 count skip
    t_byte_wr(7, 8'h80);
    t_blk_wr(2);
    t_blk_rd(3);
    t_byte_wr(7, 8'h00);
    t_blk_rd(2);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op, off;
      op = int'($urandom % 4);
      off = int'($urandom % 10);
      case (op)
        0: t_byte_wr(off, 8'($urandom));
        1: t_byte_rd(off);
        2: t_blk_wr(1 + int'($urandom % 9));
        default: t_blk_rd(1 + int'($urandom % 9));
      endcase
      if (it % 8 == 7) chk_outputs("R11 outputs random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk, bad);
    $finish;
  end
endmodule